// File: doc/BRIEF.md
# Full-Speed USB Bit-Timing Recovery

This block recovers bit timing on a full-speed USB line for a 48 MHz core. The differential pair arrives already synchronised and is sampled on every clock, which gives four samples per 12 Mbit/s bit. The block gives the downstream decoder one strobe per bit time. With that strobe it gives the line state taken near the middle of the bit. The state is passed through raw, so NRZI decoding, bit-unstuffing and end-of-packet detection all stay downstream.

A small phase counter sets when the line is sampled. A short history of recent line states shows where the most recent transition fell. Once per bit time, at a fixed counter value, the block checks that history. If the transition came early, the next sample is pulled in by one clock. If it came late, the next sample is pushed out by one clock. Otherwise the counter runs freely. Runs without edges are bounded by stuffing, and the loop holds the last phase it had across them.

Top module: `usb_fs_cdr`

## Requirements
- R1: While `rst` is high, `bit_stb` is 0 and `{bit_dp,bit_dm}` is 2'b10 (idle J). The first strobe is present after the first rising edge at which `rst` is low.
- R2: With no line transitions, `bit_stb` is high for exactly one clock in every four, and never on two clocks in a row.
- R3: `{bit_dp,bit_dm}` carries the raw line state with no decoding: J=2'b10, K=2'b01, SE0=2'b00 and SE1=2'b11. A level held steady reaches the output at the second strobe after it is first captured.
- R4: A transition first captured at the same rising edge that raises a strobe is ideal. The next strobe follows 4 clocks later.
- R5: A transition first captured one rising edge before a strobe edge is early. The next strobe follows 3 clocks later.
- R6: A transition first captured one rising edge after a strobe edge is late. The next strobe follows 5 clocks later.
- R7: When an early and a late transition show up in the same evaluation window (a two-sample glitch), no correction is made and the spacing stays at 4.
- R8: A clean stream with exactly four clocks per bit is recovered as exactly one strobe per bit, in order, with no bit missed or repeated. This holds for each of the four possible alignments of the first transition.
- R9: The block stays locked, with one strobe per bit, when the bit period is stretched or shortened by one clock every eight bits. This holds for runs of up to six bit times without a transition, and from any start in which the first transition falls early, ideal or late.
- R10: The phase is corrected at most once per bit time, at one fixed counter value. After a single correction, the spacing goes back to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 48 MHz core clock, four per bit |
| rst | input | 1 | Synchronous active-high reset |
| line_dp | input | 1 | Synchronised D+ level |
| line_dm | input | 1 | Synchronised D- level |
| bit_stb | output | 1 | One-clock pulse per recovered bit |
| bit_dp | output | 1 | D+ level of the recovered bit |
| bit_dm | output | 1 | D- level of the recovered bit |

## Verification
A phase counter that steps wrongly shows up within one bit time as strobe spacing other than 4. A correction applied in the wrong direction or at the wrong slot shows up at the next strobe as a gap of 3 or 5 where 4 was due, or the reverse. A wrong history tap or a stale sample register shows up as a recovered bit that lags or repeats. Long streams with drift expose this as a mismatch at the first bit where the sample slips past a bit edge.

// File: rtl/usb_fs_cdr_pkg.sv
package usb_fs_cdr_pkg;

    // Raw line state, encoded as {dp, dm}
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_K   = 2'b01,
        LN_J   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    // Phase action chosen at the evaluation slot
    typedef enum logic [1:0] {
        ADJ_STEP = 2'd0,
        ADJ_SKIP = 2'd1,
        ADJ_HOLD = 2'd2
    } adj_e;

    // Where the last transition sits in the history window
    typedef struct packed {
        logic early;
        logic late;
    } edge_pos_t;

    function automatic line_e to_line(input logic dp, input logic dm);
        line_e v;
        case ({dp, dm})
            2'b00:   v = LN_SE0;
            2'b01:   v = LN_K;
            2'b10:   v = LN_J;
            default: v = LN_SE1;
        endcase
        return v;
    endfunction

    // Early and late together cancel out
    function automatic adj_e pick_adj(input edge_pos_t e);
        adj_e a;
        case ({e.early, e.late})
            2'b10:   a = ADJ_SKIP;
            2'b01:   a = ADJ_HOLD;
            default: a = ADJ_STEP;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/usb_fs_cdr_hist.sv
module usb_fs_cdr_hist
    import usb_fs_cdr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  line_e                   line_i,
    output line_e [DEPTH-1:0]       hist_o,
    output edge_pos_t               edge_o
);

    line_e [DEPTH-1:0] hist_q;

    // Stage 0 holds the newest sample, stage DEPTH-1 the oldest
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) hist_q[i] <= LN_J;
                else     hist_q[i] <= line_i;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) hist_q[i] <= LN_J;
                else     hist_q[i] <= hist_q[i-1];
            end
        end
    end

    always_comb begin
        edge_o.early = (hist_q[DEPTH-1] != hist_q[DEPTH-2]);
        edge_o.late  = (hist_q[1] != hist_q[0]);
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/usb_fs_cdr_phase.sv
module usb_fs_cdr_phase
    import usb_fs_cdr_pkg::*;
#(
    parameter int OSR = 4,
    localparam int PW = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst,
    input  edge_pos_t     edge_i,
    output logic [PW-1:0] phase_o,
    output logic          zero_o
);

    localparam logic [PW-1:0] EVAL = PW'(OSR / 2);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] step;
    adj_e          adj;

    // Corrections are taken only half a bit away from the sample slot
    always_comb begin
        adj = (phase_q == EVAL) ? pick_adj(edge_i) : ADJ_STEP;
        case (adj)
            ADJ_SKIP: step = PW'(2);
            ADJ_HOLD: step = '0;
            default:  step = PW'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + step;
    end

    assign phase_o = phase_q;
    assign zero_o  = (phase_q == '0);

endmodule

// File: rtl/usb_fs_cdr_out.sv
module usb_fs_cdr_out
    import usb_fs_cdr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take_i,
    input  line_e sample_i,
    output logic  stb_o,
    output line_e line_o
);

    logic  stb_q;
    line_e line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q  <= 1'b0;
            line_q <= LN_J;
        end else begin
            stb_q <= take_i;
            if (take_i) line_q <= sample_i;
        end
    end

    assign stb_o  = stb_q;
    assign line_o = line_q;

endmodule

// File: rtl/usb_fs_cdr.sv
module usb_fs_cdr
    import usb_fs_cdr_pkg::*;
#(
    parameter int OSR = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_dp,
    input  logic line_dm,
    output logic bit_stb,
    output logic bit_dp,
    output logic bit_dm
);

    localparam int PW  = $clog2(OSR);
    localparam int TAP = OSR / 2 - 1;

    line_e             line_w;
    line_e [OSR-1:0]   hist_w;
    edge_pos_t         edge_w;
    logic [PW-1:0]     phase_q;
    logic              zero_w;
    line_e             out_w;
    line_e             tap_w;
    logic              early_w;
    logic              late_w;

    assign line_w  = to_line(line_dp, line_dm);
    assign tap_w   = hist_w[TAP];
    assign early_w = edge_w.early;
    assign late_w  = edge_w.late;

    usb_fs_cdr_hist #(.DEPTH(OSR)) u_hist (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_w),
        .hist_o (hist_w),
        .edge_o (edge_w)
    );

    usb_fs_cdr_phase #(.OSR(OSR)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .edge_i  (edge_w),
        .phase_o (phase_q),
        .zero_o  (zero_w)
    );

    usb_fs_cdr_out u_out (
        .clk      (clk),
        .rst      (rst),
        .take_i   (zero_w),
        .sample_i (tap_w),
        .stb_o    (bit_stb),
        .line_o   (out_w)
    );

    assign bit_dp = out_w[1];
    assign bit_dm = out_w[0];

endmodule

// File: rtl/usb_fs_cdr_chk.sv
module usb_fs_cdr_chk #(
    parameter int OSR = 4,
    localparam int PW = $clog2(OSR)
) (
    input logic          clk,
    input logic          rst,
    input logic          bit_stb,
    input logic          bit_dp,
    input logic          bit_dm,
    input logic [PW-1:0] phase,
    input logic          early,
    input logic          late,
    input logic [1:0]    tap
);

    localparam logic [PW-1:0] EVAL = PW'(OSR / 2);
    localparam logic [PW-1:0] SKIP_TO = PW'(OSR / 2 + 2);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!bit_stb && {bit_dp, bit_dm} == 2'b10)); // R1

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb); // R2

    AST_STB_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase == '0) |=> bit_stb); // R2

    AST_STB_ONLY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase != '0) |=> !bit_stb); // R2

    AST_SAMPLE_TAP: assert property (@(posedge clk) disable iff (rst)
        (phase == '0) |=> ({bit_dp, bit_dm} == $past(tap))); // R3

    AST_EARLY_SKIP: assert property (@(posedge clk) disable iff (rst)
        (phase == EVAL && early && !late) |=> (phase == SKIP_TO)); // R5

    AST_LATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase == EVAL && late && !early) |=> (phase == EVAL)); // R6

    AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase != EVAL || early == late) |=> (phase == PW'($past(phase) + 1'b1))); // R10

endmodule

bind usb_fs_cdr usb_fs_cdr_chk #(.OSR(OSR)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_stb (bit_stb),
    .bit_dp  (bit_dp),
    .bit_dm  (bit_dm),
    .phase   (phase_q),
    .early   (early_w),
    .late    (late_w),
    .tap     (tap_w)
);

// File: tb/usb_fs_cdr_test.sv
module usb_fs_cdr_test;

    localparam logic [1:0] LJ   = 2'b10;
    localparam logic [1:0] LK   = 2'b01;
    localparam logic [1:0] LSE0 = 2'b00;
    localparam logic [1:0] LSE1 = 2'b11;
    localparam int NSYM = 48;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] line = LJ;
    logic       bit_stb, bit_dp, bit_dm;
    logic [1:0] sym [NSYM];
    int         n_run = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    usb_fs_cdr uut (
        .clk     (clk),
        .rst     (rst),
        .line_dp (line[1]),
        .line_dm (line[0]),
        .bit_stb (bit_stb),
        .bit_dp  (bit_dp),
        .bit_dm  (bit_dm)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Returns at the negedge where reset is released
    task automatic do_reset();
        rst  = 1'b1;
        line = LJ;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Idle line: strobe every fourth clock, value J (R2, R3)
    task automatic idle_cadence();
        do_reset();
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            check(bit_stb == (j % 4 == 0), "R2", "idle strobe", int'(bit_stb), int'(j % 4 == 0));
            if (bit_stb)
                check({bit_dp, bit_dm} == LJ, "R3", "idle value", int'({bit_dp, bit_dm}), int'(LJ));
        end
    endtask

    // Constant level switched at the ideal slot (R3, R4)
    task automatic const_level(input logic [1:0] lvl);
        do_reset();
        for (int j = 0; j < 28; j++) begin
            @(negedge clk);
            check(bit_stb == (j % 4 == 0), "R4", "cadence after ideal edge", int'(bit_stb), int'(j % 4 == 0));
            if (bit_stb && j >= 8)
                check({bit_dp, bit_dm} == lvl, "R3", "raw level", int'({bit_dp, bit_dm}), int'(lvl));
            if (j == 3) line = lvl;
        end
    endtask

    // One transition (and optional return) placed around the strobe at j=4
    task automatic edge_case(input int k_set, input int k_clr, input int gap, input string req);
        int pos [8];
        int cnt = 0;
        do_reset();
        for (int j = 0; j < 24; j++) begin
            @(negedge clk);
            if (bit_stb && cnt < 8) begin
                pos[cnt] = j;
                cnt++;
            end
            if (j == k_set) line = LK;
            if (j == k_clr) line = LJ;
        end
        check(cnt >= 4, req, "strobe count", cnt, 4);
        check(pos[1] == 4, req, "strobe before edge", pos[1], 4);
        check(pos[2] - pos[1] == gap, req, "gap after edge", pos[2] - pos[1], gap);
        check(pos[3] - pos[2] == 4, "R10", "gap after correction", pos[3] - pos[2], 4);
    endtask

    task automatic build_syms(input int seed);
        logic [15:0] lfsr = 16'(seed) | 16'h0001;
        int run = 1;
        bit tog;
        sym[0] = LK;
        for (int i = 1; i < NSYM - 2; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tog = lfsr[0] || (run >= 6);
            sym[i] = tog ? ((sym[i-1] == LK) ? LJ : LK) : sym[i-1];
            run = tog ? 1 : run + 1;
        end
        sym[NSYM-2] = LSE0;
        sym[NSYM-1] = LSE0;
    endtask

    // Stream starting k clocks after the first strobe; drift per eighth bit
    task automatic run_stream(input int k, input int drift, input int seed, input string req);
        int bi = 0;
        int left = 0;
        int idx = 0;
        bit started = 1'b0;
        build_syms(seed);
        do_reset();
        for (int j = 0; j < k + NSYM * 5 + 24; j++) begin
            @(negedge clk);
            if (bit_stb) begin
                if (!started && {bit_dp, bit_dm} != LJ) started = 1'b1;
                if (started && idx < NSYM) begin
                    check({bit_dp, bit_dm} == sym[idx], req, $sformatf("bit %0d", idx),
                          int'({bit_dp, bit_dm}), int'(sym[idx]));
                    idx++;
                end
            end
            if (j == k) begin
                bi = 0;
                line = sym[0];
                left = 4 + ((0 % 8 == 7) ? drift : 0);
            end else if (j > k && bi < NSYM) begin
                left--;
                if (left == 0) begin
                    bi++;
                    if (bi < NSYM) begin
                        line = sym[bi];
                        left = 4 + ((bi % 8 == 7) ? drift : 0);
                    end else begin
                        line = LJ;
                    end
                end
            end
        end
        check(idx == NSYM, req, "recovered bit count", idx, NSYM);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
        finish_run();
    end

    initial begin
        // R1: reset state and first strobe
        repeat (2) @(negedge clk);
        check(bit_stb == 1'b0, "R1", "strobe in reset", int'(bit_stb), 0);
        check({bit_dp, bit_dm} == LJ, "R1", "value in reset", int'({bit_dp, bit_dm}), int'(LJ));
        rst = 1'b0;
        @(negedge clk);
        check(bit_stb == 1'b1, "R1", "first strobe", int'(bit_stb), 1);

        idle_cadence();
        const_level(LK);
        const_level(LSE0);
        const_level(LSE1);

        edge_case(3, -1, 4, "R4");
        edge_case(2, -1, 3, "R5");
        edge_case(4, -1, 5, "R6");
        edge_case(2, 4, 4, "R7");

        for (int k = 2; k <= 5; k++)
            for (int s = 0; s < 2; s++)
                run_stream(k, 0, 16'h1d3 + s * 16'h2a7, "R8");

        for (int k = 2; k <= 4; k++)
            for (int s = 0; s < 2; s++) begin
                run_stream(k, 1, 16'h5c1 + s * 16'h133, "R9");
                run_stream(k, -1, 16'h0e9 + s * 16'h3f1, "R9");
            end

        finish_run();
    end

endmodule